// File: doc/BRIEF.md
# Indirect Shared-Memory Access Port

This block is a register window through which a host reaches several internal word-addressed memory banks using only three register offsets. The host first writes a 32-bit control word. The upper half of that word is a routing selector that picks the target bank, and the lower half is a word index into that bank. The host then reads or writes through a data port. It can move a whole 32-bit word, or it can move one 16-bit half of the addressed word on its own.

Every access through the data port moves an internal word pointer forward by exactly one 32-bit word, even when only a 16-bit half was moved. A host can therefore stream consecutive words after writing the control word once. Each bank is a small synchronous RAM. Read data appears one cycle after the read strobe.

Top module: `shm_window`

## Requirements
- R1: After reset, a read of the control register (offset 0x160) returns 0x0001_0000: routing 0x0001 and word offset 0.
- R2: A write to offset 0x160 loads the whole 32-bit control word: routing selector in bits [31:16], word offset in bits [15:0]. A later read of 0x160 returns the stored value. Reading the control register does not move the pointer.
- R3: A 32-bit access (req_wide=1) at offset 0x164 writes or returns the full word at the current pointer.
- R4: A 16-bit access (req_wide=0) at offset 0x164 reaches bits [15:0] of the addressed word. Write data is taken from req_wdata[15:0]. Read data is returned in rsp_rdata[15:0] with bits [31:16] zero. A write leaves bits [31:16] of the word unchanged.
- R5: A 16-bit access at offset 0x166 reaches bits [31:16] of the addressed word. Data uses the same lane as in R4. A write leaves bits [15:0] of the word unchanged.
- R6: Every read or write at 0x164 or 0x166 increments the 16-bit offset field of the control register by one. This applies to 16-bit accesses as well. The new value is visible from the next cycle.
- R7: Routing values 0x0001, 0x0002, 0x0003, 0x0004, 0x0300 and 0x0301 each select a separate bank. The same offset in different banks holds independent data.
- R8: With any other routing value, data reads return zero and data writes change no bank, but the pointer still advances.
- R9: A bank is addressed by the offset modulo BANK_DEPTH (default 64). Offset 0x40 reaches word 0.
- R10: rsp_valid is high in exactly the cycle after each read strobe, and low otherwise.
- R11: Accesses at any other offset, or 32-bit accesses at 0x166, leave the control word and the banks unchanged. Reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Write strobe, one cycle per access |
| req_rd | input | 1 | Read strobe, one cycle per access |
| req_addr | input | 12 | Register byte offset |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_wdata | input | 32 | Write data (16-bit writes use bits [15:0]) |
| rsp_valid | output | 1 | Read data valid, one cycle after req_rd |
| rsp_rdata | output | 32 | Read data |

## Verification
The properties assume that the host never raises req_wr and req_rd in the same cycle. They also assume each strobe lasts one cycle and describes one access. The bench honours this by driving every access from a task that raises a single strobe for one clock and then drops it. The pointer and miss-zero properties read the internal control word, so they also rely on a control write never sharing a cycle with a data access. This follows from the single-strobe rule.

// File: rtl/shm_pkg.sv
// Shared definitions for the indirect shared-memory window.
// Assumes a fixed set of six banks identified by 16-bit routing codes.
package shm_pkg;
    localparam int NBANK = 6;
    localparam logic [11:0] OFS_CTRL = 12'h160;
    localparam logic [11:0] OFS_DLO  = 12'h164;
    localparam logic [11:0] OFS_DHI  = 12'h166;
    localparam logic [31:0] CTRL_RESET = 32'h0001_0000;
    localparam logic [15:0] ROUTE_CODE [NBANK] =
        '{16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0300, 16'h0301};

    typedef enum logic [1:0] {RSP_NONE, RSP_CTRL, RSP_DATA} rsp_kind_t;
    typedef enum logic [1:0] {LANE_WORD, LANE_LO, LANE_HI} lane_t;

    // True when the routing code maps to one of the banks.
    function automatic logic route_known(input logic [15:0] code);
        logic k;
        k = 1'b0;
        for (int i = 0; i < NBANK; i++) if (code == ROUTE_CODE[i]) k = 1'b1;
        return k;
    endfunction
endpackage

// File: rtl/shm_ctrl_reg.sv
// Control word register: routing selector in [31:16], word pointer in [15:0].
// Assumes load and step are never asserted together; load wins if they are.
module shm_ctrl_reg
    import shm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        step,
    output logic [31:0] ctrl_q
);
    // Hold, reload or advance the pointer by one word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= CTRL_RESET;
        else if (load)   ctrl_q <= load_val;
        else if (step)   ctrl_q <= {ctrl_q[31:16], ctrl_q[15:0] + 16'd1};
    end
endmodule

// File: rtl/shm_route_dec.sv
// Routing decoder: turns a 16-bit routing code into a one-hot bank select.
// Assumes the code table in shm_pkg holds distinct values.
module shm_route_dec
    import shm_pkg::*;
(
    input  logic [15:0]      route,
    output logic [NBANK-1:0] sel,
    output logic             hit
);
    genvar g;
    generate
        for (g = 0; g < NBANK; g++) begin : g_cmp
            // Compare against one table entry.
            assign sel[g] = (route == ROUTE_CODE[g]);
        end
    endgenerate
    assign hit = |sel;
endmodule

// File: rtl/shm_bank.sv
// One bank: synchronous single-port RAM, 32-bit words, per-half write enables.
// Assumes read and write are not requested in the same cycle.
module shm_bank #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    we,
    input  logic          re,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    // Write the enabled halves; register the read word.
    always_ff @(posedge clk) begin
        if (we[0]) mem[addr][15:0]  <= wdata[15:0];
        if (we[1]) mem[addr][31:16] <= wdata[31:16];
        if (re)    rdata <= mem[addr];
    end
endmodule

// File: rtl/shm_window.sv
// Indirect window top: decodes register offsets, routes data accesses to the
// bank named by the control word, and advances the pointer after each data access.
// Assumes req_wr and req_rd are single-cycle and mutually exclusive.
module shm_window
    import shm_pkg::*;
#(
    parameter int BANK_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_wr,
    input  logic        req_rd,
    input  logic [11:0] req_addr,
    input  logic        req_wide,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);
    localparam int AW = $clog2(BANK_DEPTH);

    logic             is_ctrl, is_lo, is_hi, data_hit, data_wr, data_rd;
    logic [31:0]      ctrl_q;
    logic [NBANK-1:0] sel;
    logic             route_hit;
    logic [31:0]      bank_wdata;
    logic [1:0]       bank_be;
    logic [31:0]      bank_q [NBANK];

    rsp_kind_t        kind_q;
    lane_t            lane_q, lane_d;
    logic [NBANK-1:0] sel_q;
    logic [31:0]      ctrl_snap_q;

    // Register offset decode.
    assign is_ctrl  = (req_addr == OFS_CTRL);
    assign is_lo    = (req_addr == OFS_DLO);
    assign is_hi    = (req_addr == OFS_DHI) && !req_wide;
    assign data_hit = is_lo || is_hi;
    assign data_wr  = req_wr && data_hit;
    assign data_rd  = req_rd && data_hit;

    shm_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_wr && is_ctrl),
        .load_val (req_wdata),
        .step     (data_wr || data_rd),
        .ctrl_q   (ctrl_q)
    );

    shm_route_dec u_dec (
        .route (ctrl_q[31:16]),
        .sel   (sel),
        .hit   (route_hit)
    );

    // Lane selection and write data placement for the addressed half.
    always_comb begin
        if (req_wide) begin
            lane_d     = LANE_WORD;
            bank_be    = 2'b11;
            bank_wdata = req_wdata;
        end else begin
            lane_d     = is_hi ? LANE_HI : LANE_LO;
            bank_be    = is_hi ? 2'b10 : 2'b01;
            bank_wdata = {req_wdata[15:0], req_wdata[15:0]};
        end
    end

    genvar g;
    generate
        for (g = 0; g < NBANK; g++) begin : g_bank
            shm_bank #(.DEPTH(BANK_DEPTH)) u_bank (
                .clk   (clk),
                .addr  (ctrl_q[AW-1:0]),
                .we    ((data_wr && sel[g]) ? bank_be : 2'b00),
                .re    (data_rd && sel[g]),
                .wdata (bank_wdata),
                .rdata (bank_q[g])
            );
        end
    endgenerate

    // Capture what the pending read response must return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            kind_q      <= RSP_NONE;
            lane_q      <= LANE_WORD;
            sel_q       <= '0;
            ctrl_snap_q <= '0;
        end else begin
            rsp_valid   <= req_rd;
            ctrl_snap_q <= ctrl_q;
            if (req_rd) begin
                kind_q <= is_ctrl ? RSP_CTRL : (data_hit ? RSP_DATA : RSP_NONE);
                lane_q <= lane_d;
                sel_q  <= route_hit ? sel : '0;
            end
        end
    end

    // Form the read response from the captured selection.
    always_comb begin
        logic [31:0] word;
        word = '0;
        for (int i = 0; i < NBANK; i++) if (sel_q[i]) word = word | bank_q[i];
        rsp_rdata = '0;
        if (rsp_valid) begin
            if (kind_q == RSP_CTRL) rsp_rdata = ctrl_snap_q;
            else if (kind_q == RSP_DATA) begin
                case (lane_q)
                    LANE_LO: rsp_rdata = {16'h0, word[15:0]};
                    LANE_HI: rsp_rdata = {16'h0, word[31:16]};
                    default: rsp_rdata = word;
                endcase
            end
        end
    end
endmodule

// File: rtl/shm_window_chk.sv
// Property checker for shm_window, attached by bind.
// Assumes single-cycle, mutually exclusive read and write strobes.
module shm_window_chk
    import shm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_wr,
    input logic        req_rd,
    input logic [11:0] req_addr,
    input logic        req_wide,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic [31:0] ctrl_q
);
    logic data_acc, ctrl_wr, other_wr, miss_rd;
    assign data_acc = (req_wr || req_rd) &&
                      (req_addr == OFS_DLO || (req_addr == OFS_DHI && !req_wide));
    assign ctrl_wr  = req_wr && req_addr == OFS_CTRL;
    assign other_wr = req_wr && !data_acc && !ctrl_wr;
    assign miss_rd  = req_rd && data_acc && !route_known(ctrl_q[31:16]);

    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> ctrl_q[15:0] == $past(ctrl_q[15:0]) + 16'd1);
    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ctrl_q == $past(req_wdata));
    p_rsp_after_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd |=> rsp_valid);
    p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |=> !rsp_valid);
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_rd |=> rsp_rdata == 32'h0);
    p_other_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |=> $stable(ctrl_q));
endmodule

bind shm_window shm_window_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wide  (req_wide),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .ctrl_q    (ctrl_q)
);

// File: tb/shm_window_test.sv
// Directed bench for shm_window: one task per scenario, each checking its results.
module shm_window_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 1'b0, req_rd = 1'b0, req_wide = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    shm_window uut (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_wide(req_wide), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        req_wr = 1'b1; req_addr = a; req_wide = w; req_wdata = d;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic w, output logic [31:0] d);
        @(negedge clk);
        req_rd = 1'b1; req_addr = a; req_wide = w;
        @(negedge clk);
        req_rd = 1'b0;
        check("R10 valid", {31'h0, rsp_valid}, 32'h1);
        d = rsp_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(12'h160, 1'b1, d); check("R1 reset ctrl", d, 32'h0001_0000);
    endtask

    task automatic t_ctrl;
        logic [31:0] d;
        wr(12'h160, 1'b1, 32'h0002_0007);
        rd(12'h160, 1'b1, d); check("R2 ctrl load", d, 32'h0002_0007);
        rd(12'h160, 1'b1, d); check("R2 ctrl read no step", d, 32'h0002_0007);
    endtask

    task automatic t_wide;
        logic [31:0] d;
        wr(12'h160, 1'b1, 32'h0001_0010);
        wr(12'h164, 1'b1, 32'hA5A5_1234);
        rd(12'h160, 1'b1, d); check("R6 step after write", d, 32'h0001_0011);
        wr(12'h160, 1'b1, 32'h0001_0010);
        rd(12'h164, 1'b1, d); check("R3 wide read", d, 32'hA5A5_1234);
        rd(12'h160, 1'b1, d); check("R6 step after read", d, 32'h0001_0011);
    endtask

    task automatic t_halves;
        logic [31:0] d;
        wr(12'h160, 1'b1, 32'h0001_0020);
        wr(12'h164, 1'b1, 32'h1111_2222);
        wr(12'h160, 1'b1, 32'h0001_0020);
        wr(12'h164, 1'b0, 32'hFFFF_BEEF);
        rd(12'h160, 1'b1, d); check("R6 step after half write", d, 32'h0001_0021);
        wr(12'h160, 1'b1, 32'h0001_0020);
        rd(12'h164, 1'b1, d); check("R4 low half write", d, 32'h1111_BEEF);
        wr(12'h160, 1'b1, 32'h0001_0020);
        wr(12'h166, 1'b0, 32'h0000_CAFE);
        wr(12'h160, 1'b1, 32'h0001_0020);
        rd(12'h164, 1'b1, d); check("R5 high half write", d, 32'hCAFE_BEEF);
        wr(12'h160, 1'b1, 32'h0001_0020);
        rd(12'h164, 1'b0, d); check("R4 low half read", d, 32'h0000_BEEF);
        rd(12'h160, 1'b1, d); check("R6 step after half read", d, 32'h0001_0021);
        wr(12'h160, 1'b1, 32'h0001_0020);
        rd(12'h166, 1'b0, d); check("R5 high half read", d, 32'h0000_CAFE);
    endtask

    task automatic t_banks;
        logic [31:0] d;
        logic [15:0] codes [6] = '{16'h0001, 16'h0002, 16'h0003, 16'h0004, 16'h0300, 16'h0301};
        for (int i = 0; i < 6; i++) begin
            wr(12'h160, 1'b1, {codes[i], 16'h0005});
            wr(12'h164, 1'b1, 32'h1000 + i);
        end
        for (int i = 0; i < 6; i++) begin
            wr(12'h160, 1'b1, {codes[i], 16'h0005});
            rd(12'h164, 1'b1, d); check("R7 bank separation", d, 32'h1000 + i);
        end
    endtask

    task automatic t_unknown;
        logic [31:0] d;
        wr(12'h160, 1'b1, 32'h0005_0005);
        wr(12'h164, 1'b1, 32'hDEAD_0000);
        rd(12'h160, 1'b1, d); check("R8 step on miss", d, 32'h0005_0006);
        wr(12'h160, 1'b1, 32'h0005_0005);
        rd(12'h164, 1'b1, d); check("R8 miss reads zero", d, 32'h0);
        wr(12'h160, 1'b1, 32'h0001_0005);
        rd(12'h164, 1'b1, d); check("R8 miss write dropped", d, 32'h1000);
    endtask

    task automatic t_wrap;
        logic [31:0] d;
        wr(12'h160, 1'b1, 32'h0001_003F);
        wr(12'h164, 1'b1, 32'h0BAD_F00D);
        wr(12'h164, 1'b1, 32'h600D_CAFE);
        rd(12'h160, 1'b1, d); check("R9 pointer value", d, 32'h0001_0041);
        wr(12'h160, 1'b1, 32'h0001_0000);
        rd(12'h164, 1'b1, d); check("R9 wrap to word 0", d, 32'h600D_CAFE);
    endtask

    task automatic t_other;
        logic [31:0] d;
        wr(12'h160, 1'b1, 32'h0001_0030);
        wr(12'h170, 1'b1, 32'h1234_5678);
        wr(12'h166, 1'b1, 32'h1234_5678);
        rd(12'h160, 1'b1, d); check("R11 ctrl untouched", d, 32'h0001_0030);
        rd(12'h170, 1'b1, d); check("R11 other reads zero", d, 32'h0);
        rd(12'h160, 1'b1, d); check("R11 no step", d, 32'h0001_0030);
    endtask

    task automatic t_latency;
        wr(12'h160, 1'b1, 32'h0001_0000);
        check("R10 no valid after write", {31'h0, rsp_valid}, 32'h0);
        @(negedge clk);
        check("R10 no valid idle", {31'h0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_wide();
        t_halves();
        t_banks();
        t_unknown();
        t_wrap();
        t_other();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule